// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

This block is a synchronous memory that holds 16384 data bits plus a separate 2048-bit parity store. Two fully independent ports, A and B, each have their own clock, enable, write enable, synchronous output reset and width parameter. Both ports address the same physical bits. Writing through one port at one width and reading through the other at another width therefore converts the data width. For example, 9-bit words written on A and read one bit at a time on B come out serially, with the parity bits dropped.

Each port's width parameter is 1, 2, 4, 9, 18 or 36, and its address width follows from that width. Parity bits, one per eight data bits, can only be reached by the 9, 18 and 36 bit shapes. Each port has a registered output that starts at a per-port initial value and can be forced to a per-port reset value. If both ports write the same bit in the same cycle, the stored value is undefined, and the bench never does this.

Top module: `dpram_mixed`

## Requirements
- R1: The width parameter W selects the shape: 1 gives 16K×1 (14 address bits), 2 gives 8K×2 (13), 4 gives 4K×4 (12), 9 gives 2K×(8+1) (11), 18 gives 1K×(16+2) (10), and 36 gives 512×(32+4) (9). The highest address of each shape is usable.
- R2: The data bus carries the data bits in its low positions and the parity bits (if any) directly above them. Address a of a shape with d data bits and p parity bits covers data-space bits a·d to a·d+d−1 and parity-space bits a·p to a·p+p−1, so lower addresses map to less significant bits.
- R3: Data written through one port is read back through the other port at that port's own width, following the bit mapping of R2.
- R4: The 1, 2 and 4 bit shapes neither read nor change the parity store. A narrow write leaves the parity seen by a wide port unchanged.
- R5: With enable high, write enable low and reset low, the output register shows the addressed word after the next rising edge of that port's clock.
- R6: With enable and write enable high, the addressed word is stored, and after the same edge the port's own output shows the written word (write-first).
- R7: With enable low, the port neither reads nor writes, and its output holds its value.
- R8: With enable and reset high, the output register loads the port's reset value. A write requested in the same cycle is still stored.
- R9: While `initN` is low, each output register holds the port's initial value and every data and parity bit is cleared to zero.
- R10: The two ports act in the same cycle without interfering when they touch different bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| initN | input | 1 | Active-low asynchronous initialise: loads initial output values and clears the store |
| clkA | input | 1 | Port A clock |
| enA | input | 1 | Port A enable |
| weA | input | 1 | Port A write enable |
| rstA | input | 1 | Port A synchronous output reset |
| addrA | input | addrBitsOf(WIDTH_A) | Port A word address |
| dinA | input | WIDTH_A | Port A write word, parity above data |
| doutA | output | WIDTH_A | Port A registered read word |
| clkB | input | 1 | Port B clock |
| enB | input | 1 | Port B enable |
| weB | input | 1 | Port B write enable |
| rstB | input | 1 | Port B synchronous output reset |
| addrB | input | addrBitsOf(WIDTH_B) | Port B word address |
| dinB | input | WIDTH_B | Port B write word, parity above data |
| doutB | output | WIDTH_B | Port B registered read word |

## Verification
Every port result is due one rising edge after the edge that samples the command: a read, the write-first echo, the reset value and the held value all appear in that port's output register then. The driver sets inputs on the falling edge and queues the expected word with the cycle number of the next rising edge. The monitor compares queued items only when that cycle has been reached, one nanosecond after the edge. The initialise behaviour is asynchronous, so it is checked directly while `initN` is low, before any clock edge.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Physical organisation of the shared store
  localparam int ARRAY_BITS = 16384;
  localparam int PAR_GROUP  = 8;
  localparam int ROW_BITS   = 32;
  localparam int ROW_PAR    = ROW_BITS / PAR_GROUP;
  localparam int ROWS       = ARRAY_BITS / ROW_BITS;
  localparam int ROW_AW     = $clog2(ROWS);
  localparam int LANE_AW    = $clog2(ROW_BITS);
  localparam int PLANE_AW   = $clog2(ROW_PAR);
  localparam int MAX_WIDTH  = ROW_BITS + ROW_PAR;

  // Data bits carried by a port of total width w
  function automatic int dataBitsOf(int w);
    return (w % (PAR_GROUP + 1) == 0) ? (w / (PAR_GROUP + 1)) * PAR_GROUP : w;
  endfunction

  // Parity bits carried by a port of total width w
  function automatic int parBitsOf(int w);
    return w - dataBitsOf(w);
  endfunction

  // Word address width of a port of total width w
  function automatic int addrBitsOf(int w);
    return $clog2(ARRAY_BITS / dataBitsOf(w));
  endfunction

  // Strobes from a port's control to its datapath
  typedef struct packed {
    logic                upd;   // output register takes a new value
    logic                wr;    // store the write word
    logic                clr;   // load the reset value into the output
    logic [ROW_AW-1:0]   row;   // physical row
    logic [LANE_AW-1:0]  dLane; // data bit offset inside the row
    logic [PLANE_AW-1:0] pLane; // parity bit offset inside the row
  } portStrobe_t;

endpackage

// File: rtl/dpram_port_ctrl.sv
module dpram_port_ctrl
  import dpram_pkg::*;
#(
  parameter int WIDTH = 9
) (
  input  logic                         en,
  input  logic                         we,
  input  logic                         rst,
  input  logic [addrBitsOf(WIDTH)-1:0] addr,
  output portStrobe_t                  strobe
);

  localparam int DW   = dataBitsOf(WIDTH);
  localparam int PW   = parBitsOf(WIDTH);
  localparam int AW   = addrBitsOf(WIDTH);
  localparam int SUB  = AW - ROW_AW;       // sub-word select bits
  localparam int DLOG = $clog2(DW);

  assign strobe.upd = en;
  assign strobe.wr  = en & we;
  assign strobe.clr = en & rst;

  generate
    if (SUB > 0) begin : g_narrow
      logic [SUB-1:0] sub;
      assign sub          = addr[SUB-1:0];
      assign strobe.row   = addr[AW-1:SUB];
      assign strobe.dLane = LANE_AW'(sub) << DLOG;
      if (PW > 0) begin : g_parLane
        assign strobe.pLane = PLANE_AW'(sub) << $clog2(PW);
      end else begin : g_noParLane
        assign strobe.pLane = '0;
      end
    end else begin : g_full
      assign strobe.row   = addr;
      assign strobe.dLane = '0;
      assign strobe.pLane = '0;
    end
  endgenerate

endmodule

// File: rtl/dpram_port_bank.sv
module dpram_port_bank
  import dpram_pkg::*;
#(
  parameter int                   WIDTH    = 9,
  parameter logic [MAX_WIDTH-1:0] INIT_VAL = '0,
  parameter logic [MAX_WIDTH-1:0] SRVAL    = '0
) (
  input  logic                clk,
  input  logic                initN,
  input  portStrobe_t         strobe,
  input  logic [WIDTH-1:0]    din,
  input  logic [ROW_BITS-1:0] peerD,       // peer bank at own row
  input  logic [ROW_PAR-1:0]  peerP,
  input  logic [ROW_AW-1:0]   peerRow,
  output logic [ROW_BITS-1:0] mineAtPeerD, // own bank at peer row
  output logic [ROW_PAR-1:0]  mineAtPeerP,
  output logic [WIDTH-1:0]    dout
);

  localparam int DW = dataBitsOf(WIDTH);
  localparam int PW = parBitsOf(WIDTH);
  localparam logic [ROW_BITS-1:0] D_FILL = ROW_BITS'({DW{1'b1}});

  // This port's half of the XOR-split store
  logic [ROW_BITS-1:0] memD [ROWS];
  logic [ROW_PAR-1:0]  memP [ROWS];

  logic [ROW_BITS-1:0] ownD, liveD, dMask, dNew, dAligned;
  logic [ROW_PAR-1:0]  ownP, pMask, pNew;
  logic [WIDTH-1:0]    rdWord;

  assign ownD        = memD[strobe.row];
  assign ownP        = memP[strobe.row];
  assign mineAtPeerD = memD[peerRow];
  assign mineAtPeerP = memP[peerRow];

  assign liveD    = ownD ^ peerD;
  assign dAligned = liveD >> strobe.dLane;
  assign dMask    = D_FILL << strobe.dLane;
  assign dNew     = ROW_BITS'(din[DW-1:0]) << strobe.dLane;

  generate
    if (PW > 0) begin : g_par
      localparam logic [ROW_PAR-1:0] P_FILL = ROW_PAR'({PW{1'b1}});
      logic [ROW_PAR-1:0] liveP, pAligned;
      assign liveP    = ownP ^ peerP;
      assign pAligned = liveP >> strobe.pLane;
      assign pMask    = P_FILL << strobe.pLane;
      assign pNew     = ROW_PAR'(din[WIDTH-1:DW]) << strobe.pLane;
      assign rdWord   = {pAligned[PW-1:0], dAligned[DW-1:0]};
    end else begin : g_noPar
      logic unusedLane;
      assign unusedLane = ^strobe.pLane;
      assign pMask  = '0;
      assign pNew   = '0;
      assign rdWord = dAligned[DW-1:0];

      // Narrow shapes never alter the parity store
      AST_NARROW_PAR_KEEP: assert property (@(posedge clk) disable iff (!initN)
        strobe.wr |=> memP[$past(strobe.row)] == $past(memP[strobe.row])); // R4
    end
  endgenerate

  // Store: only masked bits change, encoded against the peer half
  always_ff @(posedge clk or negedge initN) begin
    if (!initN) begin
      for (int r = 0; r < ROWS; r++) begin
        memD[r] <= '0;
        memP[r] <= '0;
      end
    end else if (strobe.wr) begin
      memD[strobe.row] <= (ownD & ~dMask) | ((dNew ^ peerD) & dMask);
      memP[strobe.row] <= (ownP & ~pMask) | ((pNew ^ peerP) & pMask);
    end
  end

  // Output register: reset value, then write-first echo, then read
  always_ff @(posedge clk or negedge initN) begin
    if (!initN) begin
      dout <= INIT_VAL[WIDTH-1:0];
    end else if (strobe.clr) begin
      dout <= SRVAL[WIDTH-1:0];
    end else if (strobe.wr) begin
      dout <= din;
    end else if (strobe.upd) begin
      dout <= rdWord;
    end
  end

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!initN)
    !strobe.upd |=> $stable(dout)); // R7

  AST_CLR_LOADS_SRVAL: assert property (@(posedge clk) disable iff (!initN)
    strobe.clr |=> dout == SRVAL[WIDTH-1:0]); // R8

  AST_WRITE_FIRST: assert property (@(posedge clk) disable iff (!initN)
    (strobe.wr && !strobe.clr) |=> dout == $past(din)); // R6

endmodule

// File: rtl/dpram_mixed.sv
module dpram_mixed
  import dpram_pkg::*;
#(
  parameter int                   WIDTH_A = 9,
  parameter int                   WIDTH_B = 1,
  parameter logic [MAX_WIDTH-1:0] INIT_A  = '0,
  parameter logic [MAX_WIDTH-1:0] SRVAL_A = '0,
  parameter logic [MAX_WIDTH-1:0] INIT_B  = '0,
  parameter logic [MAX_WIDTH-1:0] SRVAL_B = '0
) (
  input  logic                           initN,
  input  logic                           clkA,
  input  logic                           enA,
  input  logic                           weA,
  input  logic                           rstA,
  input  logic [addrBitsOf(WIDTH_A)-1:0] addrA,
  input  logic [WIDTH_A-1:0]             dinA,
  output logic [WIDTH_A-1:0]             doutA,
  input  logic                           clkB,
  input  logic                           enB,
  input  logic                           weB,
  input  logic                           rstB,
  input  logic [addrBitsOf(WIDTH_B)-1:0] addrB,
  input  logic [WIDTH_B-1:0]             dinB,
  output logic [WIDTH_B-1:0]             doutB
);

  portStrobe_t         strobeA, strobeB;
  logic [ROW_BITS-1:0] aAtRowB, bAtRowA;
  logic [ROW_PAR-1:0]  aParAtRowB, bParAtRowA;

  dpram_port_ctrl #(.WIDTH(WIDTH_A)) u_ctrlA (
    .en(enA), .we(weA), .rst(rstA), .addr(addrA), .strobe(strobeA)
  );

  dpram_port_ctrl #(.WIDTH(WIDTH_B)) u_ctrlB (
    .en(enB), .we(weB), .rst(rstB), .addr(addrB), .strobe(strobeB)
  );

  dpram_port_bank #(.WIDTH(WIDTH_A), .INIT_VAL(INIT_A), .SRVAL(SRVAL_A)) u_bankA (
    .clk(clkA), .initN(initN), .strobe(strobeA), .din(dinA),
    .peerD(bAtRowA), .peerP(bParAtRowA), .peerRow(strobeB.row),
    .mineAtPeerD(aAtRowB), .mineAtPeerP(aParAtRowB), .dout(doutA)
  );

  dpram_port_bank #(.WIDTH(WIDTH_B), .INIT_VAL(INIT_B), .SRVAL(SRVAL_B)) u_bankB (
    .clk(clkB), .initN(initN), .strobe(strobeB), .din(dinB),
    .peerD(aAtRowB), .peerP(aParAtRowB), .peerRow(strobeA.row),
    .mineAtPeerD(bAtRowA), .mineAtPeerP(bParAtRowA), .dout(doutB)
  );

endmodule

// File: tb/dpram_mixed_bench.sv
`timescale 1ns/1ps
module dpram_mixed_bench;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic initN;
  // instance 1: A = 9 bits, B = 1 bit
  logic en1A, we1A, rst1A, en1B, we1B, rst1B;
  logic [10:0] addr1A;  logic [8:0] din1A, dout1A;
  logic [13:0] addr1B;  logic [0:0] din1B, dout1B;
  // instance 2: A = 36 bits, B = 2 bits
  logic en2A, we2A, rst2A, en2B, we2B, rst2B;
  logic [8:0]  addr2A;  logic [35:0] din2A, dout2A;
  logic [12:0] addr2B;  logic [1:0]  din2B, dout2B;

  dpram_mixed #(.WIDTH_A(9), .WIDTH_B(1),
    .INIT_A(36'h155), .SRVAL_A(36'h0C3), .INIT_B(36'h1), .SRVAL_B(36'h0)) u_dpram_mixed (
    .initN(initN),
    .clkA(clk), .enA(en1A), .weA(we1A), .rstA(rst1A), .addrA(addr1A), .dinA(din1A), .doutA(dout1A),
    .clkB(clk), .enB(en1B), .weB(we1B), .rstB(rst1B), .addrB(addr1B), .dinB(din1B), .doutB(dout1B));

  dpram_mixed #(.WIDTH_A(36), .WIDTH_B(2),
    .INIT_A(36'h9_0F0F_1234), .SRVAL_A(36'h6_5A5A_00FF), .INIT_B(36'h2), .SRVAL_B(36'h1)) u_dpram_mixed_w (
    .initN(initN),
    .clkA(clk), .enA(en2A), .weA(we2A), .rstA(rst2A), .addrA(addr2A), .dinA(din2A), .doutA(dout2A),
    .clkB(clk), .enB(en2B), .weB(we2B), .rstB(rst2B), .addrB(addr2B), .dinB(din2B), .doutB(dout2B));

  // Reference store built from the requirements
  logic [16383:0] memD1, memD2;
  logic [2047:0]  memP1, memP2;
  logic [35:0]    lastExp [4];

  typedef struct {
    int          due;
    int          port;
    logic [35:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  function automatic int dwOf(int port);
    case (port) 0: return 8; 1: return 1; 2: return 32; default: return 2; endcase
  endfunction
  function automatic int pwOf(int port);
    case (port) 0: return 1; 2: return 4; default: return 0; endcase
  endfunction
  function automatic logic [35:0] initOf(int port);
    case (port) 0: return 36'h155; 1: return 36'h1; 2: return 36'h9_0F0F_1234; default: return 36'h2; endcase
  endfunction
  function automatic logic [35:0] srvalOf(int port);
    case (port) 0: return 36'h0C3; 1: return 36'h0; 2: return 36'h6_5A5A_00FF; default: return 36'h1; endcase
  endfunction
  function automatic logic [35:0] outOf(int port);
    case (port) 0: return 36'(dout1A); 1: return 36'(dout1B); 2: return dout2A; default: return 36'(dout2B); endcase
  endfunction

  // R2 mapping: word a covers bits a*d.. and parity a*p..
  function automatic logic [35:0] readModel(int port, int addr);
    logic [35:0] v = '0;
    int dw = dwOf(port);
    int pw = pwOf(port);
    for (int i = 0; i < dw; i++) v[i] = (port < 2) ? memD1[addr*dw+i] : memD2[addr*dw+i];
    for (int i = 0; i < pw; i++) v[dw+i] = (port < 2) ? memP1[addr*pw+i] : memP2[addr*pw+i];
    return v;
  endfunction

  task automatic writeModel(int port, int addr, logic [35:0] din);
    int dw = dwOf(port);
    int pw = pwOf(port);
    for (int i = 0; i < dw; i++) begin
      if (port < 2) memD1[addr*dw+i] = din[i]; else memD2[addr*dw+i] = din[i];
    end
    for (int i = 0; i < pw; i++) begin
      if (port < 2) memP1[addr*pw+i] = din[dw+i]; else memP2[addr*pw+i] = din[dw+i];
    end
  endtask

  task automatic record(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Driver: set one port's inputs and queue the result due at the next rising edge
  task automatic drive(input int port, input bit en, input bit we, input bit rst,
                       input int addr, input logic [35:0] din, input string tag);
    logic [35:0] mask, exp;
    mask = (36'd1 << (dwOf(port) + pwOf(port))) - 36'd1;
    case (port)
      0: begin en1A = en; we1A = we; rst1A = rst; addr1A = 11'(addr); din1A = din[8:0]; end
      1: begin en1B = en; we1B = we; rst1B = rst; addr1B = 14'(addr); din1B = din[0:0]; end
      2: begin en2A = en; we2A = we; rst2A = rst; addr2A = 9'(addr);  din2A = din;      end
      default: begin en2B = en; we2B = we; rst2B = rst; addr2B = 13'(addr); din2B = din[1:0]; end
    endcase
    if (!en)      exp = lastExp[port];
    else if (rst) exp = srvalOf(port);
    else if (we)  exp = din & mask;
    else          exp = readModel(port, addr);
    if (en && we) writeModel(port, addr, din);
    lastExp[port] = exp;
    q.push_back('{due: cyc + 1, port: port, exp: exp, tag: tag});
  endtask

  task automatic step();
    @(negedge clk);
    en1A = 0; we1A = 0; rst1A = 0; en1B = 0; we1B = 0; rst1B = 0;
    en2A = 0; we2A = 0; rst2A = 0; en2B = 0; we2B = 0; rst2B = 0;
  endtask

  task automatic applyInit();
    memD1 = '0; memD2 = '0; memP1 = '0; memP2 = '0;
    for (int p = 0; p < 4; p++) lastExp[p] = initOf(p);
  endtask

  // Cycle counter and monitor
  initial forever begin
    @(posedge clk);
    cyc++;
  end

  initial forever begin
    @(posedge clk);
    #1;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      logic [35:0] act;
      it  = q.pop_front();
      act = outOf(it.port);
      record(act === it.exp, $sformatf("%s (port %0d)", it.tag, it.port), act, it.exp);
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    initN = 0;
    step();
    addr1A = '0; din1A = '0; addr1B = '0; din1B = '0;
    addr2A = '0; din2A = '0; addr2B = '0; din2B = '0;
    applyInit();
    repeat (2) @(negedge clk);
    for (int p = 0; p < 4; p++) record(outOf(p) === initOf(p), "R9 initial output value", outOf(p), initOf(p));
    initN = 1;

    // ---- 9-bit / 1-bit instance ----
    drive(1, 1, 0, 0, 5, 0, "R9 store cleared");                 step();
    drive(0, 1, 1, 0, 3, 36'h1A5, "R6 write-first echo");         step();
    for (int i = 0; i < 8; i++) begin
      drive(1, 1, 0, 0, 24 + i, 0, "R2 R3 serial readout");       step();
    end
    drive(1, 1, 1, 0, 25, 36'h1, "R6 narrow write echo");         step();
    drive(0, 1, 0, 0, 3, 0, "R4 R5 parity kept after narrow write"); step();
    drive(0, 0, 1, 0, 3, 36'h0FF, "R7 disabled port holds");      step();
    drive(0, 1, 0, 0, 3, 0, "R7 disabled write not stored");      step();
    drive(0, 1, 1, 1, 4, 36'h13C, "R8 reset value loaded");       step();
    drive(0, 1, 0, 0, 4, 0, "R8 write during reset stored");      step();
    drive(0, 1, 1, 0, 10, 36'h0E1, "R10 port A write");
    drive(1, 1, 0, 0, 26, 0, "R10 port B read same cycle");       step();
    drive(1, 1, 0, 0, 80, 0, "R10 read back other port");         step();
    drive(0, 1, 1, 0, 2047, 36'h1FF, "R1 top 9-bit address");     step();
    drive(1, 1, 0, 0, 16383, 0, "R1 top 1-bit address");          step();
    drive(1, 1, 1, 1, 7, 36'h1, "R8 narrow reset value");         step();

    // ---- 36-bit / 2-bit instance ----
    drive(2, 1, 1, 0, 7, 36'hF_89AB_CDEF, "R6 wide write echo");  step();
    for (int i = 0; i < 16; i++) begin
      drive(3, 1, 0, 0, 112 + i, 0, "R2 R3 2-bit readout");       step();
    end
    drive(3, 1, 1, 0, 127, 36'h1, "R6 2-bit write echo");         step();
    drive(2, 1, 0, 0, 7, 0, "R3 R4 R5 wide readback");            step();
    drive(3, 0, 0, 0, 0, 0, "R7 narrow port holds");              step();
    drive(2, 1, 1, 1, 9, 36'h0_0000_0001, "R8 wide reset value"); step();
    drive(2, 1, 0, 0, 9, 0, "R8 wide write during reset stored"); step();
    drive(2, 1, 1, 0, 511, 36'hA_C000_0000, "R1 top 36-bit address");
    drive(3, 1, 0, 0, 20, 0, "R10 narrow read beside wide write"); step();
    drive(3, 1, 0, 0, 8191, 0, "R1 top 2-bit address");           step();

    // ---- initialise again after activity ----
    repeat (2) step();
    initN = 0;
    #1;
    applyInit();
    for (int p = 0; p < 4; p++) record(outOf(p) === initOf(p), "R9 re-init output value", outOf(p), initOf(p));
    @(negedge clk);
    initN = 1;
    drive(0, 1, 0, 0, 3, 0, "R9 contents cleared");
    drive(2, 1, 0, 0, 7, 0, "R9 wide contents cleared");          step();

    repeat (3) step();
    if (q.size() != 0) record(1'b0, "R5 results still pending", 36'(q.size()), 36'd0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule